// File: doc/BRIEF.md
# Ethernet ingress ARP responder and IPv4 forwarder

This block sits on the receive side of an Ethernet link interface and looks at one frame byte per cycle. The byte stream carries the whole frame: destination and source MAC, EtherType, payload, any padding and the four CRC bytes. The block reads the EtherType at frame bytes 12 and 13. Frames typed 0x0800 lose their 14-byte Ethernet header, their padding and their CRC. What is left is the IPv4 datagram, and it goes out on a payload stream tagged with a configurable base channel. Frames typed 0x0806 are parsed as ARP. Frames of any other type are discarded, and an error counter records them.

A well-formed ARP frame has hardware type 0x0001 and protocol type 0x0800. For such a frame, the sender IP and sender MAC are always written into a direct-mapped table that never ages, whatever the opcode or target. After that the target IP is compared with the three configured own addresses. A request (opcode 1) aimed at one of those addresses makes the block send a 42-byte ARP reply. The reply has the sender and target fields exchanged, opcode 2 and fresh Ethernet addresses, and the reply stream carries no CRC. Software can read any table slot through a read port.

Top module: `eth_arp_ingress`

## Requirements
- R1: An EtherType 0x0800 frame is forwarded one byte per cycle, starting at frame byte 14. Each payload byte appears on `ip_data` with `ip_valid` high one cycle after it is accepted, and `ip_chan` equals `cfg_base_chan`.
- R2: The number of forwarded bytes equals the IPv4 total length held in frame bytes 16–17 (big-endian, at least 20). Padding and CRC bytes are not forwarded, and `ip_last` marks the final byte of that length.
- R3: An ARP frame (EtherType 0x0806) whose hardware type at bytes 14–15 is not 0x0001 writes nothing to the table and produces no reply.
- R4: An ARP frame whose protocol type at bytes 16–17 is not 0x0800 writes nothing to the table and produces no reply.
- R5: A valid ARP frame, at least 42 bytes long, writes its sender MAC (bytes 22–27) and sender IP (bytes 28–31) into the table slot given by the low log2(TBL_DEPTH) bits of that IP. This happens whatever the opcode or target, and the slot then reads back as valid with those values.
- R6: A valid request (opcode 0x0001 at bytes 20–21) whose target IP (bytes 38–41) equals one of `cfg_own_ip0..2` yields a 42-byte reply on `rp_data`. Byte 0 of the reply appears two cycles after the request's last byte is accepted, and `rp_last` is on byte 41. The reply layout is: requester MAC, own MAC, 0x0806, 0x0001, 0x0800, 0x06, 0x04, opcode 0x0002, own MAC, the requested own IP, requester MAC, requester IP.
- R7: A valid request whose target matches none of the three own addresses produces no reply, but its sender is still learned.
- R8: A valid ARP frame with opcode 0x0002 is learned and produces no reply.
- R9: A frame with any EtherType other than 0x0800 or 0x0806 produces no output on either stream, and `err_count` rises by exactly one.
- R10: A second sender that maps to an occupied slot replaces the earlier entry completely.
- R11: Table entries stay valid and unchanged however many idle cycles pass.
- R12: After reset both streams are idle, `err_count` is zero and every table slot reads as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received frame byte present |
| in_data | input | 8 | Received frame byte |
| in_last | input | 1 | Final byte of the frame (CRC included) |
| cfg_own_mac | input | 48 | Own MAC address used in replies |
| cfg_own_ip0 | input | 32 | First own IP address |
| cfg_own_ip1 | input | 32 | Second own IP address |
| cfg_own_ip2 | input | 32 | Third own IP address |
| cfg_base_chan | input | CHW | Channel tag for forwarded IPv4 datagrams |
| tbl_rd_idx | input | IDXW | Table slot to read |
| tbl_rd_valid | output | 1 | Slot holds an entry (registered) |
| tbl_rd_ip | output | 32 | Stored IP of the slot (registered) |
| tbl_rd_mac | output | 48 | Stored MAC of the slot (registered) |
| ip_valid | output | 1 | Forwarded datagram byte present |
| ip_data | output | 8 | Forwarded datagram byte |
| ip_last | output | 1 | Final datagram byte |
| ip_chan | output | CHW | Channel tag of the datagram |
| rp_valid | output | 1 | ARP reply byte present |
| rp_data | output | 8 | ARP reply byte |
| rp_last | output | 1 | Final reply byte |
| err_count | output | ERRW | Count of frames with an unsupported EtherType |

## Verification
Forwarded datagram bytes come out one cycle after the frame byte that carries them is accepted. A reply's first byte comes out two cycles after the request's last byte. A learned entry can be seen on the read port one cycle after the read index is applied, once two cycles have passed since the frame ended. The bench stamps every driven byte and every captured output byte with the count of rising edges. It compares those stamps for exact latency, and it compares the payload and reply contents byte by byte with images built from the requirements. It drives inputs and reads outputs on falling edges only, and it reads the table and the error counter only after a long idle gap has let every frame-end effect settle.

// File: rtl/eth_ingress_pkg.sv
package eth_ingress_pkg;
    localparam int OFFW       = 11;
    localparam int REPLY_LEN  = 42;
    localparam int REPLY_BITS = REPLY_LEN * 8;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [15:0] ETYPE_ARP  = 16'h0806;
    localparam logic [15:0] HWTYPE_ETH = 16'h0001;
    localparam logic [15:0] OPC_REQ    = 16'h0001;
    localparam logic [15:0] OPC_REP    = 16'h0002;
    localparam logic [7:0]  HW_ADDR_SZ = 8'h06;
    localparam logic [7:0]  PR_ADDR_SZ = 8'h04;
endpackage

// File: rtl/eth_rx_parser.sv
module eth_rx_parser
    import eth_ingress_pkg::*;
#(
    parameter int CHW  = 4,
    parameter int ERRW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_last,
    input  logic [31:0]     own_ip0,
    input  logic [31:0]     own_ip1,
    input  logic [31:0]     own_ip2,
    input  logic [CHW-1:0]  base_chan,
    output logic            ip_valid,
    output logic [7:0]      ip_data,
    output logic            ip_last,
    output logic [CHW-1:0]  ip_chan,
    output logic            learn_we,
    output logic            reply_go,
    output logic [47:0]     snd_mac,
    output logic [31:0]     snd_ip,
    output logic [31:0]     tgt_ip,
    output logic [ERRW-1:0] err_count
);
    typedef struct packed {
        logic [OFFW-1:0] off;
        logic [15:0]     etype;
        logic [15:0]     htype;
        logic [15:0]     w16b;   // ARP protocol type or IPv4 total length
        logic [15:0]     opc;
        logic [47:0]     sha;
        logic [31:0]     spa;
        logic [31:0]     tpa;
        logic            ipv;
        logic [7:0]      ipd;
        logic            ipl;
        logic [CHW-1:0]  ipc;
        logic            learn;
        logic            go;
        logic [ERRW-1:0] err;
    } prs_t;

    prs_t s_q, s_d;
    logic [OFFW-1:0] o;
    logic [15:0]     pos16;
    logic            arp_ok;
    logic            is_own;

    always_comb begin
        s_d       = s_q;
        s_d.ipv   = 1'b0;
        s_d.ipl   = 1'b0;
        s_d.learn = 1'b0;
        s_d.go    = 1'b0;
        o         = s_q.off;
        pos16     = {{(16-OFFW){1'b0}}, o} - 16'd14;
        arp_ok    = 1'b0;
        is_own    = 1'b0;
        if (in_valid) begin
            case (o)
                11'd12: s_d.etype[15:8] = in_data;
                11'd13: s_d.etype[7:0]  = in_data;
                11'd14: s_d.htype[15:8] = in_data;
                11'd15: s_d.htype[7:0]  = in_data;
                11'd16: s_d.w16b[15:8]  = in_data;
                11'd17: s_d.w16b[7:0]   = in_data;
                11'd20: s_d.opc[15:8]   = in_data;
                11'd21: s_d.opc[7:0]    = in_data;
                default: ;
            endcase
            if (o >= 11'd22 && o <= 11'd27) s_d.sha = {s_q.sha[39:0], in_data};
            if (o >= 11'd28 && o <= 11'd31) s_d.spa = {s_q.spa[23:0], in_data};
            if (o >= 11'd38 && o <= 11'd41) s_d.tpa = {s_q.tpa[23:0], in_data};

            // payload forwarding, bounded by the datagram's own length
            if (o >= 11'd14 && s_q.etype == ETYPE_IPV4 &&
                (o < 11'd18 || pos16 < s_q.w16b)) begin
                s_d.ipv = 1'b1;
                s_d.ipd = in_data;
                s_d.ipc = base_chan;
                s_d.ipl = in_last || (o >= 11'd18 && pos16 == s_q.w16b - 16'd1);
            end

            if (in_last) begin
                s_d.off = '0;
                arp_ok  = (o >= 11'd41) && (s_d.etype == ETYPE_ARP) &&
                          (s_d.htype == HWTYPE_ETH) && (s_d.w16b == ETYPE_IPV4);
                is_own  = (s_d.tpa == own_ip0) || (s_d.tpa == own_ip1) ||
                          (s_d.tpa == own_ip2);
                s_d.learn = arp_ok;
                s_d.go    = arp_ok && (s_d.opc == OPC_REQ) && is_own;
                if (o < 11'd13 ||
                    (s_d.etype != ETYPE_IPV4 && s_d.etype != ETYPE_ARP))
                    s_d.err = s_q.err + 1'b1;
            end else if (!(&o)) begin
                s_d.off = o + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ip_valid  = s_q.ipv;
    assign ip_data   = s_q.ipd;
    assign ip_last   = s_q.ipl;
    assign ip_chan   = s_q.ipc;
    assign learn_we  = s_q.learn;
    assign reply_go  = s_q.go;
    assign snd_mac   = s_q.sha;
    assign snd_ip    = s_q.spa;
    assign tgt_ip    = s_q.tpa;
    assign err_count = s_q.err;
endmodule

// File: rtl/arp_table.sv
module arp_table #(
    parameter int DEPTH = 16,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [31:0]     wr_ip,
    input  logic [47:0]     wr_mac,
    input  logic [IDXW-1:0] rd_idx,
    output logic            rd_valid,
    output logic [31:0]     rd_ip,
    output logic [47:0]     rd_mac
);
    typedef struct packed {
        logic [DEPTH-1:0]        vld;
        logic [DEPTH-1:0][31:0]  ip;
        logic [DEPTH-1:0][47:0]  mac;
        logic                    rv;
        logic [31:0]             rip;
        logic [47:0]             rmac;
    } tbl_t;

    tbl_t t_q, t_d;
    logic [IDXW-1:0] widx;

    always_comb begin
        t_d    = t_q;
        widx   = wr_ip[IDXW-1:0];
        t_d.rv   = t_q.vld[rd_idx];
        t_d.rip  = t_q.ip[rd_idx];
        t_d.rmac = t_q.mac[rd_idx];
        if (wr_en) begin
            t_d.vld[widx] = 1'b1;
            t_d.ip[widx]  = wr_ip;
            t_d.mac[widx] = wr_mac;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign rd_valid = t_q.rv;
    assign rd_ip    = t_q.rip;
    assign rd_mac   = t_q.rmac;
endmodule

// File: rtl/arp_reply_tx.sv
module arp_reply_tx
    import eth_ingress_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [47:0] own_mac,
    input  logic [47:0] req_mac,
    input  logic [31:0] req_ip,
    input  logic [31:0] asked_ip,
    output logic        rp_valid,
    output logic [7:0]  rp_data,
    output logic        rp_last
);
    typedef struct packed {
        logic                  busy;
        logic [5:0]            cnt;
        logic [REPLY_BITS-1:0] sh;
    } tx_t;

    tx_t x_q, x_d;

    always_comb begin
        x_d = x_q;
        if (x_q.busy) begin
            x_d.sh  = {x_q.sh[REPLY_BITS-9:0], 8'h00};
            x_d.cnt = x_q.cnt + 6'd1;
            if (x_q.cnt == 6'(REPLY_LEN - 1)) x_d.busy = 1'b0;
        end else if (go) begin
            x_d.busy = 1'b1;
            x_d.cnt  = '0;
            x_d.sh   = {req_mac, own_mac, ETYPE_ARP, HWTYPE_ETH, ETYPE_IPV4,
                        HW_ADDR_SZ, PR_ADDR_SZ, OPC_REP,
                        own_mac, asked_ip, req_mac, req_ip};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) x_q <= '0;
        else     x_q <= x_d;
    end

    assign rp_valid = x_q.busy;
    assign rp_data  = x_q.sh[REPLY_BITS-1 -: 8];
    assign rp_last  = x_q.busy && (x_q.cnt == 6'(REPLY_LEN - 1));
endmodule

// File: rtl/eth_arp_ingress.sv
module eth_arp_ingress #(
    parameter int TBL_DEPTH = 16,
    parameter int CHW       = 4,
    parameter int ERRW      = 16,
    parameter int IDXW      = $clog2(TBL_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_last,
    input  logic [47:0]     cfg_own_mac,
    input  logic [31:0]     cfg_own_ip0,
    input  logic [31:0]     cfg_own_ip1,
    input  logic [31:0]     cfg_own_ip2,
    input  logic [CHW-1:0]  cfg_base_chan,
    input  logic [IDXW-1:0] tbl_rd_idx,
    output logic            tbl_rd_valid,
    output logic [31:0]     tbl_rd_ip,
    output logic [47:0]     tbl_rd_mac,
    output logic            ip_valid,
    output logic [7:0]      ip_data,
    output logic            ip_last,
    output logic [CHW-1:0]  ip_chan,
    output logic            rp_valid,
    output logic [7:0]      rp_data,
    output logic            rp_last,
    output logic [ERRW-1:0] err_count
);
    logic        learn_we, reply_go;
    logic [47:0] snd_mac;
    logic [31:0] snd_ip, tgt_ip;

    eth_rx_parser #(.CHW(CHW), .ERRW(ERRW)) u_parse (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .own_ip0(cfg_own_ip0), .own_ip1(cfg_own_ip1), .own_ip2(cfg_own_ip2),
        .base_chan(cfg_base_chan),
        .ip_valid(ip_valid), .ip_data(ip_data), .ip_last(ip_last), .ip_chan(ip_chan),
        .learn_we(learn_we), .reply_go(reply_go),
        .snd_mac(snd_mac), .snd_ip(snd_ip), .tgt_ip(tgt_ip), .err_count(err_count)
    );

    arp_table #(.DEPTH(TBL_DEPTH), .IDXW(IDXW)) u_tbl (
        .clk(clk), .rst(rst), .wr_en(learn_we), .wr_ip(snd_ip), .wr_mac(snd_mac),
        .rd_idx(tbl_rd_idx), .rd_valid(tbl_rd_valid), .rd_ip(tbl_rd_ip), .rd_mac(tbl_rd_mac)
    );

    arp_reply_tx u_tx (
        .clk(clk), .rst(rst), .go(reply_go), .own_mac(cfg_own_mac),
        .req_mac(snd_mac), .req_ip(snd_ip), .asked_ip(tgt_ip),
        .rp_valid(rp_valid), .rp_data(rp_data), .rp_last(rp_last)
    );
endmodule

// File: rtl/eth_arp_ingress_chk.sv
module eth_arp_ingress_chk #(
    parameter int ERRW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_last,
    input logic            ip_valid,
    input logic            ip_last,
    input logic            rp_valid,
    input logic [7:0]      rp_data,
    input logic            rp_last,
    input logic [ERRW-1:0] err_count
);
    logic [5:0] rp_seen_q;

    always_ff @(posedge clk) begin
        if (rst)                      rp_seen_q <= '0;
        else if (rp_valid && !rp_last) rp_seen_q <= rp_seen_q + 6'd1;
        else                          rp_seen_q <= '0;
    end

    p_ip_follows_input_r1: assert property (@(posedge clk) disable iff (rst)
        ip_valid |-> $past(in_valid));
    p_ip_last_in_byte_r2: assert property (@(posedge clk) disable iff (rst)
        ip_last |-> ip_valid);
    p_reply_length_r6: assert property (@(posedge clk) disable iff (rst)
        (rp_valid && rp_last) |-> (rp_seen_q == 6'd41));
    p_reply_ethertype_r6: assert property (@(posedge clk) disable iff (rst)
        (rp_valid && rp_seen_q == 6'd12) |-> (rp_data == 8'h08));
    p_reply_ends_clean_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rp_valid) |-> $past(rp_last));
    p_err_single_step_r9: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |->
            ($past(in_valid && in_last) && err_count == $past(err_count) + 1'b1));
endmodule

bind eth_arp_ingress eth_arp_ingress_chk #(.ERRW(ERRW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .ip_valid(ip_valid), .ip_last(ip_last),
    .rp_valid(rp_valid), .rp_data(rp_data), .rp_last(rp_last),
    .err_count(err_count)
);

// File: tb/sim_eth_arp_ingress.sv
module sim_eth_arp_ingress;
    localparam int CHW = 4, ERRW = 16, IDXW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [47:0] own_mac = 48'h02_11_22_33_44_55;
    logic [31:0] own0 = 32'h0A00_0001, own1 = 32'h0A00_0101, own2 = 32'hC0A8_0509;
    logic [CHW-1:0] base_chan = 4'd5;
    logic [IDXW-1:0] rd_idx = '0;
    logic tv; logic [31:0] tip; logic [47:0] tmac;
    logic ipv, ipl, rpv, rpl;
    logic [7:0] ipd, rpd;
    logic [CHW-1:0] ipc;
    logic [ERRW-1:0] errc;

    always #5 clk = ~clk;

    eth_arp_ingress #(.TBL_DEPTH(16), .CHW(CHW), .ERRW(ERRW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .cfg_own_mac(own_mac), .cfg_own_ip0(own0), .cfg_own_ip1(own1), .cfg_own_ip2(own2),
        .cfg_base_chan(base_chan), .tbl_rd_idx(rd_idx),
        .tbl_rd_valid(tv), .tbl_rd_ip(tip), .tbl_rd_mac(tmac),
        .ip_valid(ipv), .ip_data(ipd), .ip_last(ipl), .ip_chan(ipc),
        .rp_valid(rpv), .rp_data(rpd), .rp_last(rpl), .err_count(errc)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic [7:0] fb [0:255];
    int fn = 0;
    int drv_cyc [0:255];
    logic [7:0] ip_buf [0:2047]; int ip_at [0:2047]; int ip_n = 0; int ip_lastpos = -1;
    logic [CHW-1:0] ip_chan_seen = '0;
    logic [7:0] rp_buf [0:511];  int rp_at [0:511];  int rp_n = 0; int rp_lastpos = -1;
    logic [7:0] exp_rp [0:41];
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ipv) begin
            ip_buf[ip_n] <= ipd; ip_at[ip_n] <= cyc; ip_chan_seen <= ipc;
            if (ipl) ip_lastpos <= ip_n;
            ip_n <= ip_n + 1;
        end
        if (rpv) begin
            rp_buf[rp_n] <= rpd; rp_at[rp_n] <= cyc;
            if (rpl) rp_lastpos <= rp_n;
            rp_n <= rp_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send();
        for (int i = 0; i < fn; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb[i]; in_last = (i == fn - 1);
            drv_cyc[i] = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic put(input int at, input int nb, input logic [63:0] v);
        for (int k = 0; k < nb; k++) fb[at + k] = v[8*(nb-1-k) +: 8];
    endtask

    task automatic build_arp(input logic [15:0] ht, input logic [15:0] pt, input logic [15:0] op,
                             input logic [47:0] sha, input logic [31:0] spa, input logic [31:0] tpa);
        put(0, 6, 48'hFFFF_FFFF_FFFF); put(6, 6, sha); put(12, 2, 16'h0806);
        put(14, 2, ht); put(16, 2, pt); fb[18] = 8'h06; fb[19] = 8'h04; put(20, 2, op);
        put(22, 6, sha); put(28, 4, spa); put(32, 6, 48'h0); put(38, 4, tpa);
        for (int k = 42; k < 60; k++) fb[k] = 8'h00;
        put(60, 4, 32'hDEAD_BEEF);
        fn = 64;
    endtask

    task automatic rd_tbl(input logic [IDXW-1:0] idx);
        @(negedge clk); rd_idx = idx;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 ip_valid", ipv, 0); chk("R12 rp_valid", rpv, 0); chk("R12 err_count", errc, 0);
        for (int k = 0; k < 16; k++) begin
            rd_tbl(k[IDXW-1:0]);
            chk($sformatf("R12 slot %0d invalid", k), tv, 0);
        end
    endtask

    task automatic t_request(input logic [31:0] asked, input logic [47:0] sha, input logic [31:0] spa);
        int rb = rp_n; int bad = 0;
        build_arp(16'h0001, 16'h0800, 16'h0001, sha, spa, asked);
        send();
        chk("R6 reply byte count", rp_n - rb, 42);
        chk("R6 last flag position", rp_lastpos - rb, 41);
        chk("R6 reply latency", rp_at[rb] - drv_cyc[fn-1], 2);
        for (int k = 0; k < 6; k++) begin
            exp_rp[k] = sha[8*(5-k) +: 8]; exp_rp[6+k] = own_mac[8*(5-k) +: 8];
            exp_rp[22+k] = own_mac[8*(5-k) +: 8]; exp_rp[32+k] = sha[8*(5-k) +: 8];
        end
        exp_rp[12] = 8'h08; exp_rp[13] = 8'h06; exp_rp[14] = 8'h00; exp_rp[15] = 8'h01;
        exp_rp[16] = 8'h08; exp_rp[17] = 8'h00; exp_rp[18] = 8'h06; exp_rp[19] = 8'h04;
        exp_rp[20] = 8'h00; exp_rp[21] = 8'h02;
        for (int k = 0; k < 4; k++) begin
            exp_rp[28+k] = asked[8*(3-k) +: 8]; exp_rp[38+k] = spa[8*(3-k) +: 8];
        end
        for (int k = 0; k < 42; k++) if (rp_buf[rb+k] !== exp_rp[k]) bad++;
        chk("R6 reply content mismatching bytes", bad, 0);
        rd_tbl(spa[IDXW-1:0]);
        chk("R5 learned valid", tv, 1); chk("R5 learned ip", tip, spa); chk("R5 learned mac", tmac, sha);
    endtask

    task automatic t_not_ours();
        int rb = rp_n;
        build_arp(16'h0001, 16'h0800, 16'h0001, 48'h0A_0B_0C_0D_0E_07, 32'h0A00_0047, 32'h0A00_0099);
        send();
        chk("R7 no reply for foreign target", rp_n - rb, 0);
        rd_tbl(4'h7);
        chk("R7 sender still learned", tv, 1); chk("R7 learned ip", tip, 32'h0A00_0047);
    endtask

    task automatic t_reply_in();
        int rb = rp_n;
        build_arp(16'h0001, 16'h0800, 16'h0002, 48'h0A_0B_0C_0D_0E_08, 32'h0A00_0058, own1);
        send();
        chk("R8 opcode 2 gives no reply", rp_n - rb, 0);
        rd_tbl(4'h8);
        chk("R8 opcode 2 learned mac", tmac, 48'h0A_0B_0C_0D_0E_08);
    endtask

    task automatic t_bad(input bit hw, input logic [31:0] spa);
        int rb = rp_n;
        if (hw) build_arp(16'h0006, 16'h0800, 16'h0001, 48'h0E_0E_0E_0E_0E_0E, spa, own0);
        else    build_arp(16'h0001, 16'h86DD, 16'h0001, 48'h0E_0E_0E_0E_0E_0E, spa, own0);
        send();
        rd_tbl(spa[IDXW-1:0]);
        if (hw) begin
            chk("R3 bad hardware type: no reply", rp_n - rb, 0);
            chk("R3 bad hardware type: slot untouched", tv, 0);
        end else begin
            chk("R4 bad protocol type: no reply", rp_n - rb, 0);
            chk("R4 bad protocol type: slot untouched", tv, 0);
        end
    endtask

    task automatic t_ipv4(input int len);
        int ib = ip_n; int bad = 0; int body;
        put(0, 6, own_mac); put(6, 6, 48'h0C_0C_0C_0C_0C_01); put(12, 2, 16'h0800);
        fb[14] = 8'h45; fb[15] = 8'h00; put(16, 2, len[15:0]);
        for (int k = 18; k < 14 + len; k++) fb[k] = 8'((k * 7 + 3) & 255);
        body = (14 + len < 60) ? 60 : 14 + len;
        for (int k = 14 + len; k < body; k++) fb[k] = 8'hA5;
        put(body, 4, 32'h1234_5678);
        fn = body + 4;
        send();
        chk($sformatf("R2 forwarded count len=%0d", len), ip_n - ib, len);
        chk($sformatf("R2 last flag len=%0d", len), ip_lastpos - ib, len - 1);
        for (int k = 0; k < len; k++) if (ip_buf[ib+k] !== fb[14+k]) bad++;
        chk($sformatf("R1 payload mismatching bytes len=%0d", len), bad, 0);
        chk("R1 forwarding latency", ip_at[ib] - drv_cyc[14], 1);
        chk("R1 channel tag", ip_chan_seen, base_chan);
    endtask

    task automatic t_other();
        int ib = ip_n; int rb = rp_n; logic [ERRW-1:0] e0 = errc;
        build_arp(16'h0001, 16'h0800, 16'h0001, 48'h0D_0D_0D_0D_0D_0D, 32'h0A00_0001, own0);
        put(12, 2, 16'h88CC);
        send();
        chk("R9 err_count step", errc, e0 + 1'b1);
        chk("R9 no payload output", ip_n - ib, 0);
        chk("R9 no reply output", rp_n - rb, 0);
    endtask

    task automatic t_replace();
        build_arp(16'h0001, 16'h0800, 16'h0002, 48'h0A_AA_AA_AA_AA_01, 32'h0A00_0723, own0);
        send();
        build_arp(16'h0001, 16'h0800, 16'h0002, 48'h0B_BB_BB_BB_BB_02, 32'h0A09_0913, own0);
        send();
        rd_tbl(4'h3);
        chk("R10 replaced ip", tip, 32'h0A09_0913);
        chk("R10 replaced mac", tmac, 48'h0B_BB_BB_BB_BB_02);
    endtask

    task automatic t_no_aging();
        repeat (3000) @(negedge clk);
        rd_tbl(4'h3);
        chk("R11 entry kept after idle", tv, 1);
        chk("R11 entry mac unchanged", tmac, 48'h0B_BB_BB_BB_BB_02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_request(own1, 48'h0A_0B_0C_0D_0E_01, 32'h0A00_0031);
        t_request(own2, 48'h0A_0B_0C_0D_0E_02, 32'h0A00_0042);
        t_request(own0, 48'h0A_0B_0C_0D_0E_05, 32'h0A00_0065);
        t_not_ours();
        t_reply_in();
        t_bad(1'b1, 32'h0A00_009A);
        t_bad(1'b0, 32'h0A00_009B);
        t_ipv4(28);
        t_ipv4(100);
        t_other();
        t_replace();
        t_no_aging();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule